// File: doc/BRIEF.md
# Octal Buffer Boundary Cell Chain

This block is the boundary register of an eight-channel tri-state buffer that is split into two four-channel groups. Each group has an active-low enable. The register holds eighteen cells. Ten cells watch the inputs: two enables and eight data lines. Eight cells watch the outputs. Every cell has two stages. A scan stage is clocked on the rising test-clock edge. A hold stage is clocked on the falling edge and feeds the pins or the core. The block takes its capture, shift and update strobes from an external test-port controller, together with a three-bit decoded instruction. It returns the serial output of the chain.

While no test instruction is active, the block is a plain buffer: each output follows its data input while its group enable is low. Under the test instructions the hold stages take over the core inputs and the output pins. They can also force every output off, invert the captured contents for a self-check, or flip the output cells on every clock while the controller idles. Pattern-generation and signature modes live outside the block. They read the scan stages through `cell_q` and write them back through the parallel-load port.

Top module: `boundary_chain`

## Requirements
- R1: When `shift_en` is high and the instruction selects the chain (codes 1, 2, 5, 6), each rising edge moves the chain one place towards bit 0. `tdi` enters bit 17, and `tdo_bsr` always shows bit 0.
- R2: Bit 17 holds group-1 enable `oe_n_in[1]` and bit 16 holds group-2 enable `oe_n_in[0]`. Bits 15..8 hold `a_in[7:0]` and bits 7..0 hold output channels `y_out[7:0]`. Group 1 is channels 7..4 and group 2 is channels 3..0.
- R3: Under codes 0 (bypass), 2 (sample), 5 (read) and 6 (self-check) the block buffers normally. `y_out` equals `a_in`, and `y_en` of a channel is high exactly when its group's `oe_n_in` bit is low.
- R4: A capture under code 1 (external test) or code 2 loads the pin enables and data into bits 17..8. It loads the value seen by the core into bits 7..0. That value is `a_in` in normal operation and hold bits 15..8 under test drive.
- R5: Under codes 1, 4 (clamp) and 7 (toggle), `y_out` comes from hold bits 7..0. A group's `y_en` is the inverse of hold bit 17 or 16.
- R6: A capture under code 6 loads every scan stage with the inverse of its own hold stage.
- R7: A capture under code 5 leaves every scan stage unchanged.
- R8: Under code 3 (all-off), `y_en` is zero on every channel. Shift and update strobes leave the chain and the outputs unchanged.
- R9: Under code 4, the chain is outside the scan path. Shift, capture and update strobes change neither the scan stages nor the pins.
- R10: Under code 7 with `run_idle` high, each rising edge inverts scan bits 7..0 and each falling edge copies them into hold bits 7..0. Bits 17..8 keep their value.
- R11: When `update_en` is high and the chain is selected, the hold stages take the scan-stage values on the falling edge.
- R12: When `pload_en` is high, all scan stages load `pload_data` on the rising edge. All hold stages copy them on the next falling edge. This load wins over capture and shift.
- R13: Only `rst_n` clears the cells. With every strobe low, both stages keep their contents however the pins move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; scan stages on the rising edge, hold stages on the falling edge |
| rst_n | input | 1 | Asynchronous power-up clear, active low |
| instr | input | 3 | Decoded instruction code 0..7 |
| capture_en | input | 1 | Capture strobe from the port controller |
| shift_en | input | 1 | Shift strobe from the port controller |
| update_en | input | 1 | Update strobe from the port controller |
| run_idle | input | 1 | Controller is in its run/idle state |
| tdi | input | 1 | Serial data into bit 17 |
| pload_en | input | 1 | Parallel load of the scan stages |
| pload_data | input | 18 | Parallel load value |
| oe_n_in | input | 2 | Group enables, active low; bit 1 is group 1 |
| a_in | input | 8 | Buffer data inputs |
| y_out | output | 8 | Buffer data outputs |
| y_en | output | 8 | Per-channel output drive enable; low means high impedance |
| cell_q | output | 18 | Scan-stage contents for external pattern logic |
| tdo_bsr | output | 1 | Serial data out of bit 0 |

## Verification
The assertions check on every rising edge the single-step scan motion, the unchanged chain after a read capture, the inverted image after a self-check capture, and the inversion-only motion under toggle. They also check the silence of the chain under the non-scan instructions, the parallel-load result, the forced-off outputs and the normal buffer path. The bench shows what needs a history or a falling edge. That covers the fixed bit order after a full eighteen-bit scan, hold stages driving the pins only after an update, and the core value that lands in the output cells during an external-test capture. It also covers a load arriving together with capture and shift, and retention through long idle stretches with moving pins.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [2:0] {
        INS_BYPASS   = 3'd0,
        INS_EXTEST   = 3'd1,
        INS_SAMPLE   = 3'd2,
        INS_HIGHZ    = 3'd3,
        INS_CLAMP    = 3'd4,
        INS_READ     = 3'd5,
        INS_SELFTEST = 3'd6,
        INS_TOGGLE   = 3'd7
    } bsr_instr_e;

    // Control derived from the instruction code
    typedef struct packed {
        logic bsr_sel;     // chain is in the scan path
        logic test_drive;  // hold stages feed core and pins
        logic out_hiz;     // all outputs forced off
        logic cap_pins;    // capture pins and core outputs
        logic cap_hold;    // capture keeps current content
        logic cap_inv;     // capture inverts hold stage
        logic toggle;      // output cells flip in run/idle
    } bsr_mode_t;

    // Next-state record of one cell
    typedef struct packed {
        logic stage;
        logic latch;
    } cell_state_t;

endpackage

// File: rtl/bsr_mode_decode.sv
module bsr_mode_decode
    import bsr_pkg::*;
(
    input  logic [2:0] instr,
    output bsr_mode_t  mode
);

    always_comb begin
        mode = '0;
        case (bsr_instr_e'(instr))
            INS_EXTEST: begin
                mode.bsr_sel    = 1'b1;
                mode.test_drive = 1'b1;
                mode.cap_pins   = 1'b1;
            end
            INS_SAMPLE: begin
                mode.bsr_sel  = 1'b1;
                mode.cap_pins = 1'b1;
            end
            INS_HIGHZ: begin
                mode.out_hiz = 1'b1;
            end
            INS_CLAMP: begin
                mode.test_drive = 1'b1;
            end
            INS_READ: begin
                mode.bsr_sel  = 1'b1;
                mode.cap_hold = 1'b1;
            end
            INS_SELFTEST: begin
                mode.bsr_sel = 1'b1;
                mode.cap_inv = 1'b1;
            end
            INS_TOGGLE: begin
                mode.test_drive = 1'b1;
                mode.toggle     = 1'b1;
            end
            default: begin
                mode = '0;
            end
        endcase
    end

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
    import bsr_pkg::*;
#(
    parameter bit CAN_TOGGLE = 1'b0
) (
    input  logic tck,
    input  logic rst_n,
    input  logic load_en,
    input  logic load_val,
    input  logic cap_en,
    input  logic cap_val,
    input  logic shift_en,
    input  logic shift_in,
    input  logic tog_en,
    input  logic upd_en,
    output logic stage_q,
    output logic latch_q
);

    cell_state_t st_d;

    always_comb begin
        st_d.stage = stage_q;
        if (load_en) begin
            st_d.stage = load_val;
        end else if (cap_en) begin
            st_d.stage = cap_val;
        end else if (shift_en) begin
            st_d.stage = shift_in;
        end else if (tog_en && CAN_TOGGLE) begin
            st_d.stage = ~stage_q;
        end
        st_d.latch = upd_en ? stage_q : latch_q;
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= 1'b0;
        end else begin
            stage_q <= st_d.stage;
        end
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
        end else begin
            latch_q <= st_d.latch;
        end
    end

endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux
    import bsr_pkg::*;
#(
    parameter int N_GRP = 2,
    parameter int GRP_W = 4,
    localparam int N_DATA  = N_GRP * GRP_W,
    localparam int N_CELLS = N_GRP + 2 * N_DATA
) (
    input  bsr_mode_t           mode,
    input  logic [N_CELLS-1:0]  latch,
    input  logic [N_GRP-1:0]    oe_n_in,
    input  logic [N_DATA-1:0]   a_in,
    output logic [N_DATA-1:0]   core_a,
    output logic [N_DATA-1:0]   y_out,
    output logic [N_DATA-1:0]   y_en
);

    logic [N_GRP-1:0]  oe_lat;
    logic [N_DATA-1:0] a_lat;
    logic [N_DATA-1:0] y_lat;
    logic [N_GRP-1:0]  oe_src;

    assign oe_lat = latch[N_CELLS-1 -: N_GRP];
    assign a_lat  = latch[2*N_DATA-1 -: N_DATA];
    assign y_lat  = latch[N_DATA-1:0];

    assign core_a = mode.test_drive ? a_lat  : a_in;
    assign oe_src = mode.test_drive ? oe_lat : oe_n_in;

    for (genvar k = 0; k < N_DATA; k++) begin : g_chan
        localparam int GRP_IDX = k / GRP_W;
        assign y_out[k] = mode.test_drive ? y_lat[k] : core_a[k];
        assign y_en[k]  = !mode.out_hiz && !oe_src[GRP_IDX];
    end

endmodule

// File: rtl/boundary_chain.sv
module boundary_chain
    import bsr_pkg::*;
#(
    parameter int N_GRP = 2,
    parameter int GRP_W = 4
) (
    input  logic                           tck,
    input  logic                           rst_n,
    input  logic [2:0]                     instr,
    input  logic                           capture_en,
    input  logic                           shift_en,
    input  logic                           update_en,
    input  logic                           run_idle,
    input  logic                           tdi,
    input  logic                           pload_en,
    input  logic [N_GRP+2*N_GRP*GRP_W-1:0] pload_data,
    input  logic [N_GRP-1:0]               oe_n_in,
    input  logic [N_GRP*GRP_W-1:0]         a_in,
    output logic [N_GRP*GRP_W-1:0]         y_out,
    output logic [N_GRP*GRP_W-1:0]         y_en,
    output logic [N_GRP+2*N_GRP*GRP_W-1:0] cell_q,
    output logic                           tdo_bsr
);

    localparam int N_DATA  = N_GRP * GRP_W;
    localparam int N_IN    = N_GRP + N_DATA;
    localparam int N_CELLS = N_IN + N_DATA;

    bsr_mode_t          mode;
    logic [N_CELLS-1:0] stage_q;
    logic [N_CELLS-1:0] latch_q;
    logic [N_CELLS-1:0] cap_val_d;
    logic [N_CELLS:0]   chain;
    logic [N_DATA-1:0]  core_a;
    logic [N_IN-1:0]    pin_vec;
    logic               scan_go;
    logic               tog_go;

    bsr_mode_decode u_dec (
        .instr (instr),
        .mode  (mode)
    );

    bsr_pin_mux #(
        .N_GRP (N_GRP),
        .GRP_W (GRP_W)
    ) u_mux (
        .mode    (mode),
        .latch   (latch_q),
        .oe_n_in (oe_n_in),
        .a_in    (a_in),
        .core_a  (core_a),
        .y_out   (y_out),
        .y_en    (y_en)
    );

    assign pin_vec = {oe_n_in, a_in};
    assign chain   = {tdi, stage_q};
    assign scan_go = shift_en && mode.bsr_sel;
    assign tog_go  = run_idle && mode.toggle;

    // Capture source per cell: inverted hold, own value, or pin/core value
    always_comb begin
        for (int i = 0; i < N_DATA; i++) begin
            if (mode.cap_inv)       cap_val_d[i] = ~latch_q[i];
            else if (mode.cap_hold) cap_val_d[i] = stage_q[i];
            else                    cap_val_d[i] = core_a[i];
        end
        for (int j = 0; j < N_IN; j++) begin
            if (mode.cap_inv)       cap_val_d[N_DATA+j] = ~latch_q[N_DATA+j];
            else if (mode.cap_hold) cap_val_d[N_DATA+j] = stage_q[N_DATA+j];
            else                    cap_val_d[N_DATA+j] = pin_vec[j];
        end
    end

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        localparam bit IS_OUT = (i < N_DATA);
        logic upd_cell;
        assign upd_cell = pload_en || (update_en && mode.bsr_sel) || (IS_OUT && tog_go);
        bsr_cell #(
            .CAN_TOGGLE (IS_OUT)
        ) u_cell (
            .tck      (tck),
            .rst_n    (rst_n),
            .load_en  (pload_en),
            .load_val (pload_data[i]),
            .cap_en   (capture_en && mode.bsr_sel),
            .cap_val  (cap_val_d[i]),
            .shift_en (scan_go),
            .shift_in (chain[i+1]),
            .tog_en   (tog_go),
            .upd_en   (upd_cell),
            .stage_q  (stage_q[i]),
            .latch_q  (latch_q[i])
        );
    end

    assign cell_q  = stage_q;
    assign tdo_bsr = stage_q[0];

    // ---------------- assertions ----------------
    p_scan_step_r1: assert property (@(posedge tck) disable iff (!rst_n)
        (shift_en && !capture_en && !pload_en &&
         (instr == 3'd1 || instr == 3'd2 || instr == 3'd5 || instr == 3'd6))
        |=> cell_q == {$past(tdi), $past(cell_q[N_CELLS-1:1])});

    p_normal_buffer_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (instr == 3'd0 || instr == 3'd2 || instr == 3'd5 || instr == 3'd6)
        |-> (y_out == a_in) &&
            (y_en == {{GRP_W{~oe_n_in[1]}}, {GRP_W{~oe_n_in[0]}}}));

    p_selftest_inverts_r6: assert property (@(posedge tck) disable iff (!rst_n)
        (capture_en && !pload_en && instr == 3'd6)
        |=> cell_q == ~$past(latch_q));

    p_read_keeps_r7: assert property (@(posedge tck) disable iff (!rst_n)
        (capture_en && !pload_en && instr == 3'd5)
        |=> cell_q == $past(cell_q));

    p_outputs_off_r8: assert property (@(posedge tck) disable iff (!rst_n)
        (instr == 3'd3) |-> (y_en == '0));

    p_nonscan_quiet_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (!pload_en && (instr == 3'd0 || instr == 3'd3 || instr == 3'd4))
        |=> $stable(cell_q));

    p_toggle_flip_r10: assert property (@(posedge tck) disable iff (!rst_n)
        (run_idle && instr == 3'd7 && !pload_en)
        |=> (cell_q[N_DATA-1:0] == ~$past(cell_q[N_DATA-1:0])) &&
            (cell_q[N_CELLS-1:N_DATA] == $past(cell_q[N_CELLS-1:N_DATA])));

    p_parallel_load_r12: assert property (@(posedge tck) disable iff (!rst_n)
        pload_en |=> cell_q == $past(pload_data));

endmodule

// File: tb/boundary_chain_tb_top.sv
module boundary_chain_tb_top;

    logic        tck = 1'b0;
    logic        rst_n;
    logic [2:0]  ins;
    logic        cap, sh, upd, run, tdi, pl;
    logic [17:0] pd;
    logic [1:0]  oe;
    logic [7:0]  a;
    logic [7:0]  y_out, y_en;
    logic [17:0] cell_q;
    logic        tdo;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference state: scan stages and hold stages
    logic [17:0] ms = '0;
    logic [17:0] mh = '0;

    always #4 tck = ~tck;   // 125 MHz

    boundary_chain dut_i (
        .tck        (tck),
        .rst_n      (rst_n),
        .instr      (ins),
        .capture_en (cap),
        .shift_en   (sh),
        .update_en  (upd),
        .run_idle   (run),
        .tdi        (tdi),
        .pload_en   (pl),
        .pload_data (pd),
        .oe_n_in    (oe),
        .a_in       (a),
        .y_out      (y_out),
        .y_en       (y_en),
        .cell_q     (cell_q),
        .tdo_bsr    (tdo)
    );

    function automatic bit on_chain(logic [2:0] i);
        return (i == 3'd1) || (i == 3'd2) || (i == 3'd5) || (i == 3'd6);
    endfunction

    function automatic bit drives_test(logic [2:0] i);
        return (i == 3'd1) || (i == 3'd4) || (i == 3'd7);
    endfunction

    function automatic logic [7:0] exp_y();
        return drives_test(ins) ? mh[7:0] : a;
    endfunction

    function automatic logic [7:0] exp_en();
        logic [1:0] src;
        if (ins == 3'd3) return 8'h00;
        src = drives_test(ins) ? mh[17:16] : oe;
        return {{4{~src[1]}}, {4{~src[0]}}};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [17:0] act, input logic [17:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag);
        logic [17:0] ns;
        logic [7:0]  core;
        @(posedge tck);
        core = drives_test(ins) ? mh[15:8] : a;
        ns = ms;
        if (!rst_n) ns = '0;
        else if (pl) ns = pd;
        else if (cap && on_chain(ins)) begin
            if (ins == 3'd1 || ins == 3'd2) ns = {oe, a, core};
            else if (ins == 3'd6) ns = ~mh;
        end
        else if (sh && on_chain(ins)) ns = {tdi, ms[17:1]};
        else if (run && ins == 3'd7) ns[7:0] = ~ms[7:0];
        ms = ns;
        @(negedge tck);
        if (!rst_n) mh = '0;
        else if (pl || (upd && on_chain(ins))) mh = ms;
        else if (run && ins == 3'd7) mh[7:0] = ms[7:0];
        #2;
        chk(tag, "cell_q", cell_q, ms);
        chk(tag, "tdo", {17'd0, tdo}, {17'd0, ms[0]});
        chk(tag, "y_out", {10'd0, y_out}, {10'd0, exp_y()});
        chk(tag, "y_en", {10'd0, y_en}, {10'd0, exp_en()});
    endtask

    task automatic strobes_off();
        cap = 0; sh = 0; upd = 0; run = 0; pl = 0;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R13 watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin : stim
        logic [17:0] v;
        logic [17:0] keep;
        rst_n = 0; ins = 3'd0; tdi = 0; pd = '0; oe = 2'b00; a = 8'hA5;
        strobes_off();
        step("R13"); step("R13");
        chk("R13", "reset cells", cell_q, 18'h0);
        rst_n = 1;

        // R3 normal buffering under several enable patterns
        ins = 3'd0; oe = 2'b01; a = 8'h3C; step("R3");
        oe = 2'b10; a = 8'hC3; step("R3");
        chk("R3", "grp2 only", {10'd0, y_en}, {10'd0, 8'h0F});
        oe = 2'b11; a = 8'h5F; step("R3");

        // R4 sample capture, R2 field layout
        ins = 3'd2; oe = 2'b10; a = 8'h96; cap = 1; step("R4");
        cap = 0;
        chk("R2", "sample layout", cell_q, {2'b10, 8'h96, 8'h96});

        // R1 full scan, lsb of the value entering first
        v = {2'b01, 8'h5A, 8'hC3};
        sh = 1;
        for (int k = 0; k < 18; k++) begin
            tdi = v[k];
            step("R1");
        end
        sh = 0;
        chk("R1", "scanned value", cell_q, v);

        // R11 update copies scan to hold
        upd = 1; step("R11"); upd = 0;
        // R5 external test drives pins from hold
        ins = 3'd1; a = 8'h00; oe = 2'b11; step("R5");
        chk("R5", "y from hold", {10'd0, y_out}, {10'd0, 8'hC3});
        chk("R5", "en from hold", {10'd0, y_en}, {10'd0, 8'hF0});

        // R4 external-test capture sees core fed from hold
        a = 8'h0F; cap = 1; step("R4"); cap = 0;
        chk("R4", "extest capture", cell_q, {2'b11, 8'h0F, 8'h5A});

        // R6 self-check capture inverts hold
        ins = 3'd6; cap = 1; step("R6"); cap = 0;
        chk("R6", "inverted hold", cell_q, ~v);

        // R7 read capture keeps content
        ins = 3'd5; keep = cell_q; cap = 1; step("R7"); step("R7"); cap = 0;
        chk("R7", "read hold", cell_q, keep);

        // R8 all-off ignores shift and update
        ins = 3'd3; sh = 1; upd = 1; tdi = 1; step("R8"); step("R8");
        sh = 0; upd = 0;
        chk("R8", "outputs off", {10'd0, y_en}, {10'd0, 8'h00});
        chk("R8", "chain kept", cell_q, keep);

        // R9 clamp ignores scan strobes, pins from hold
        ins = 3'd4; sh = 1; cap = 1; upd = 1; tdi = 0; step("R9"); step("R9");
        strobes_off();
        chk("R9", "clamp pins", {10'd0, y_out}, {10'd0, 8'hC3});
        chk("R9", "chain kept", cell_q, keep);

        // R10 toggle in run/idle
        ins = 3'd7; run = 1;
        step("R10"); step("R10"); step("R10");
        run = 0;
        chk("R10", "outputs flipped", cell_q, {keep[17:8], ~keep[7:0]});
        chk("R10", "pins follow", {10'd0, y_out}, {10'd0, ~keep[7:0]});

        // R12 parallel load wins over capture and shift (also R14-style priority)
        ins = 3'd2; pl = 1; cap = 1; sh = 1; pd = 18'h2B3C7; step("R12");
        strobes_off();
        chk("R12", "loaded", cell_q, 18'h2B3C7);
        ins = 3'd1; step("R12");
        chk("R12", "hold loaded", {10'd0, y_out}, {10'd0, 8'hC7});

        // R13 retention with moving pins
        for (int k = 0; k < 20; k++) begin
            a = 8'(k * 37); oe = 2'(k);
            step("R13");
        end
        chk("R13", "retained", cell_q, 18'h2B3C7);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule